// File: doc/BRIEF.md
# Main Oscillator Frequency Monitor

This block checks an external main oscillator against an internal reference oscillator that always runs. A counter in the main-clock domain counts main-clock edges. A window timer in the reference domain asks for that count once every fixed number of reference cycles. The two domains exchange the count through a toggle handshake, with each direction synchronized through two flops. The reference side compares each count with a programmable pair of bounds. If the count is below the lower bound, or if no answer comes back because the main clock has stopped, the main clock is too slow. If the count is above the upper bound, it is too fast.

When a failure is found, the block moves its clock-select output over to the internal oscillator. It then raises one of two requests, chosen by a control bit: a one-cycle request to the reset controller, or an interrupt that stays set until software clears it. The failure cause is kept in status bits. Only a power-on reset or a write-one-to-clear access clears them, so they survive the system reset that the block itself asks for.

Software uses a four-word register port in the reference domain. Word 0 is control: bit 0 enables checking, bit 1 selects the interrupt action, and bit 2 selects the main clock. Word 1 is status. Word 2 holds the bounds. Word 3 reads as zero.

Top module: `osc_freq_monitor`

## Requirements
- R1: When a measured window count lies within [lower, upper] inclusive, no status bit is set, `irq` and `rst_req` stay low, and `sel_main` keeps the value software wrote.
- R2: A window count greater than the upper bound is a failure and sets status bit 0 (failure) and status bit 1 (too fast).
- R3: A window count less than the lower bound is a failure and sets status bit 0 and status bit 2 (too slow).
- R4: If the main clock stops, status bits 0 and 2 are set within two windows, and status bit 1 is not set.
- R5: While control bit 0 (enable) is 0, no failure is reported: status stays 0, `irq` and `rst_req` stay low, and `sel_main` is unchanged.
- R6: With control bit 1 at 1, a failure sets `irq`. `irq` stays high until a write to word 1 with bit 0 set, and `rst_req` stays low.
- R7: With control bit 1 at 0, each failure gives a `rst_req` pulse exactly one reference cycle long, and `irq` stays low.
- R8: Any failure drives `sel_main` to 0. It stays 0 until software writes control bit 2 = 1, and a good clock alone does not restore it.
- R9: Each status bit is cleared only by `por_rst` or by writing 1 to that bit. Writing 0 has no effect, and `sys_rst` leaves the status bits unchanged while it clears the control bits.
- R10: After `por_rst`, control reads 0, status reads 0, `sel_main` is 0, and word 2 reads {upper, lower} = {DEF_HI, DEF_LO}, with the upper bound in bits 31:16 and the lower bound in bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Internal reference clock; also clocks the register port |
| main_clk | input | 1 | Main oscillator under test |
| por_rst | input | 1 | Power-on reset, synchronous, active high; clears everything |
| sys_rst | input | 1 | System reset, synchronous, active high; keeps status bits and clock selection |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from the address) |
| sel_main | output | 1 | 1 selects the main clock, 0 selects the internal clock |
| rst_req | output | 1 | Reset request pulse |
| irq | output | 1 | Interrupt request, level |

## Verification
The hardest case to reach is a main clock that stops completely. In that case no count ever returns, so the failure has to come from the outstanding-request timeout and not from a comparison. The bench gates its main-clock generator off in the middle of a run, while checking is enabled, and waits several windows for the too-slow bit. The other hard case is telling the interrupt hold and the clock-select latch apart from a failure that is still going on. For that, the bench restores a good main clock before it clears status and re-selects the main clock, so that any later change can only come from stored state.

// File: rtl/osc_mon_pkg.sv
`timescale 1ns/1ps
package osc_mon_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_STAT  = 2'd1,
        ADDR_LIMIT = 2'd2,
        ADDR_RSVD  = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        VERDICT_OK,
        VERDICT_SLOW,
        VERDICT_FAST
    } verdict_e;

    typedef struct packed {
        logic sel_main;
        logic act_irq;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic slow;
        logic fast;
        logic fail;
    } stat_t;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_ACT_BIT  = 1;
    localparam int CTRL_SEL_BIT  = 2;
    localparam int STAT_FAIL_BIT = 0;
    localparam int STAT_FAST_BIT = 1;
    localparam int STAT_SLOW_BIT = 2;
    localparam int LIMIT_HI_LSB  = 16;

    function automatic verdict_e classify(input logic [31:0] cnt,
                                          input logic [31:0] lo,
                                          input logic [31:0] hi);
        if (cnt < lo)      return VERDICT_SLOW;
        else if (cnt > hi) return VERDICT_FAST;
        else               return VERDICT_OK;
    endfunction

endpackage

// File: rtl/osc_sync.sv
`timescale 1ns/1ps
module osc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/osc_edge_counter.sv
`timescale 1ns/1ps
module osc_edge_counter #(
    parameter int CNT_W     = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic             main_clk,
    input  logic             ref_rst,
    input  logic             req_t,
    output logic [CNT_W-1:0] hold_cnt,
    output logic             ack_t
);
    logic             main_rst;
    logic             req_s;
    logic             req_d;
    logic [CNT_W-1:0] cnt;

    osc_sync #(.STAGES(SYNC_STGS)) u_rst_sync (
        .clk(main_clk), .rst(1'b0), .d(ref_rst), .q(main_rst)
    );

    osc_sync #(.STAGES(SYNC_STGS)) u_req_sync (
        .clk(main_clk), .rst(main_rst), .d(req_t), .q(req_s)
    );

    always_ff @(posedge main_clk) begin
        if (main_rst) begin
            cnt      <= '0;
            hold_cnt <= '0;
            req_d    <= 1'b0;
            ack_t    <= 1'b0;
        end else begin
            req_d <= req_s;
            if (req_s != req_d) begin
                hold_cnt <= cnt;
                cnt      <= '0;
                ack_t    <= req_s;
            end else if (cnt != {CNT_W{1'b1}}) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/osc_meas_ctrl.sv
`timescale 1ns/1ps
module osc_meas_ctrl #(
    parameter int WIN_CYCLES = 64,
    parameter int CNT_W      = 16,
    parameter int SYNC_STGS  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             ack_t,
    input  logic [CNT_W-1:0] hold_cnt,
    output logic             req_t,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_cnt,
    output logic             meas_stall
);
    localparam int WIN_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);

    logic [WIN_W-1:0] win_cnt;
    logic             ack_s;
    logic             ack_q;
    logic             armed;
    logic             pending;
    logic             ack_new;
    logic             win_end;

    osc_sync #(.STAGES(SYNC_STGS)) u_ack_sync (
        .clk(clk), .rst(rst), .d(ack_t), .q(ack_s)
    );

    assign pending = (req_t != ack_s);
    assign ack_new = (ack_s != ack_q);
    assign win_end = (win_cnt == WIN_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt    <= '0;
            req_t      <= 1'b0;
            ack_q      <= 1'b0;
            armed      <= 1'b0;
            meas_valid <= 1'b0;
            meas_stall <= 1'b0;
            meas_cnt   <= '0;
        end else begin
            win_cnt <= win_end ? '0 : win_cnt + 1'b1;
            ack_q   <= ack_s;
            if (win_end && !pending)
                req_t <= ~req_t;
            if (!en)                  armed <= 1'b0;
            else if (win_end && pending) armed <= 1'b0;
            else if (ack_new)         armed <= 1'b1;
            if (ack_new)
                meas_cnt <= hold_cnt;
            meas_valid <= ack_new && en && armed;
            meas_stall <= win_end && pending && en;
        end
    end
endmodule

// File: rtl/osc_mon_regs.sv
`timescale 1ns/1ps
module osc_mon_regs
    import osc_mon_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DEF_LO = 48,
    parameter int DEF_HI = 80
) (
    input  logic             clk,
    input  logic             por_rst,
    input  logic             sys_rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic             meas_valid,
    input  logic [CNT_W-1:0] meas_cnt,
    input  logic             meas_stall,
    output ctrl_t            ctrl_q,
    output stat_t            stat_q,
    output logic             rst_req,
    output logic             irq
);
    logic             rst_any;
    logic [CNT_W-1:0] lim_lo;
    logic [CNT_W-1:0] lim_hi;
    verdict_e         verdict;
    logic             fail_now;
    stat_t            set_bits;
    stat_t            clr_bits;
    logic             wr_ctrl, wr_stat, wr_lim;
    logic             unused_ok;

    assign rst_any = por_rst | sys_rst;
    assign wr_ctrl = we && (reg_addr_e'(addr) == ADDR_CTRL);
    assign wr_stat = we && (reg_addr_e'(addr) == ADDR_STAT);
    assign wr_lim  = we && (reg_addr_e'(addr) == ADDR_LIMIT);
    assign unused_ok = ^{wdata[31:LIMIT_HI_LSB+CNT_W], wdata[LIMIT_HI_LSB-1:CNT_W]};

    always_comb begin
        if (meas_stall)      verdict = VERDICT_SLOW;
        else if (meas_valid) verdict = classify(32'(meas_cnt), 32'(lim_lo), 32'(lim_hi));
        else                 verdict = VERDICT_OK;
        fail_now      = ctrl_q.en && (verdict != VERDICT_OK);
        set_bits.fail = fail_now;
        set_bits.fast = fail_now && (verdict == VERDICT_FAST);
        set_bits.slow = fail_now && (verdict == VERDICT_SLOW);
        clr_bits.fail = wr_stat && wdata[STAT_FAIL_BIT];
        clr_bits.fast = wr_stat && wdata[STAT_FAST_BIT];
        clr_bits.slow = wr_stat && wdata[STAT_SLOW_BIT];
    end

    // control bits: cleared by either reset
    always_ff @(posedge clk) begin
        if (rst_any) begin
            ctrl_q.en      <= 1'b0;
            ctrl_q.act_irq <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_q.en      <= wdata[CTRL_EN_BIT];
            ctrl_q.act_irq <= wdata[CTRL_ACT_BIT];
        end
    end

    // clock selection: forced fallback wins over a write in the same cycle
    always_ff @(posedge clk) begin
        if (por_rst)      ctrl_q.sel_main <= 1'b0;
        else if (fail_now) ctrl_q.sel_main <= 1'b0;
        else if (wr_ctrl) ctrl_q.sel_main <= wdata[CTRL_SEL_BIT];
    end

    // cause bits survive the system reset
    always_ff @(posedge clk) begin
        if (por_rst) stat_q <= '0;
        else         stat_q <= set_bits | (stat_q & ~clr_bits);
    end

    always_ff @(posedge clk) begin
        if (rst_any) begin
            irq     <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            if (fail_now && ctrl_q.act_irq) irq <= 1'b1;
            else if (clr_bits.fail)         irq <= 1'b0;
            rst_req <= fail_now && !ctrl_q.act_irq;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_any) begin
            lim_lo <= CNT_W'(DEF_LO);
            lim_hi <= CNT_W'(DEF_HI);
        end else if (wr_lim) begin
            lim_lo <= wdata[CNT_W-1:0];
            lim_hi <= wdata[LIMIT_HI_LSB +: CNT_W];
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            ADDR_CTRL:  rdata[2:0] = ctrl_q;
            ADDR_STAT:  rdata[2:0] = stat_q;
            ADDR_LIMIT: begin
                rdata[CNT_W-1:0]                = lim_lo;
                rdata[LIMIT_HI_LSB +: CNT_W]    = lim_hi;
            end
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/osc_freq_monitor.sv
`timescale 1ns/1ps
module osc_freq_monitor
    import osc_mon_pkg::*;
#(
    parameter int WIN_CYCLES = 64,
    parameter int CNT_W      = 16,
    parameter int SYNC_STGS  = 2,
    parameter int DEF_LO     = 48,
    parameter int DEF_HI     = 80
) (
    input  logic        ref_clk,
    input  logic        main_clk,
    input  logic        por_rst,
    input  logic        sys_rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        sel_main,
    output logic        rst_req,
    output logic        irq
);
    logic             hs_rst;
    logic             req_t;
    logic             ack_t;
    logic [CNT_W-1:0] hold_cnt;
    logic             meas_valid;
    logic [CNT_W-1:0] meas_cnt;
    logic             meas_stall;
    ctrl_t            ctrl_q;
    stat_t            stat_q;
    logic             ctrl_en;
    logic             ctrl_act;
    logic             sts_fail;

    assign hs_rst   = por_rst | sys_rst;
    assign ctrl_en  = ctrl_q.en;
    assign ctrl_act = ctrl_q.act_irq;
    assign sts_fail = stat_q.fail;
    assign sel_main = ctrl_q.sel_main;

    osc_edge_counter #(.CNT_W(CNT_W), .SYNC_STGS(SYNC_STGS)) u_cnt (
        .main_clk(main_clk), .ref_rst(hs_rst), .req_t(req_t),
        .hold_cnt(hold_cnt), .ack_t(ack_t)
    );

    osc_meas_ctrl #(.WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W), .SYNC_STGS(SYNC_STGS)) u_meas (
        .clk(ref_clk), .rst(hs_rst), .en(ctrl_en), .ack_t(ack_t),
        .hold_cnt(hold_cnt), .req_t(req_t), .meas_valid(meas_valid),
        .meas_cnt(meas_cnt), .meas_stall(meas_stall)
    );

    osc_mon_regs #(.CNT_W(CNT_W), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_regs (
        .clk(ref_clk), .por_rst(por_rst), .sys_rst(sys_rst),
        .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .meas_valid(meas_valid), .meas_cnt(meas_cnt), .meas_stall(meas_stall),
        .ctrl_q(ctrl_q), .stat_q(stat_q), .rst_req(rst_req), .irq(irq)
    );
endmodule

// File: rtl/osc_freq_monitor_chk.sv
`timescale 1ns/1ps
module osc_freq_monitor_chk (
    input logic        ref_clk,
    input logic        por_rst,
    input logic        sys_rst,
    input logic        reg_we,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        sel_main,
    input logic        rst_req,
    input logic        irq,
    input logic        ctrl_en,
    input logic        ctrl_act,
    input logic        sts_fail
);
    p_quiet_when_off_r5: assert property (@(posedge ref_clk) disable iff (por_rst || sys_rst)
        !ctrl_en |=> (!rst_req && !$rose(irq)));

    p_irq_has_cause_r6: assert property (@(posedge ref_clk) disable iff (por_rst || sys_rst)
        irq |-> sts_fail);

    p_rstreq_single_r7: assert property (@(posedge ref_clk) disable iff (por_rst || sys_rst)
        rst_req |=> !rst_req);

    p_rstreq_mode_r7: assert property (@(posedge ref_clk) disable iff (por_rst || sys_rst)
        rst_req |-> !$past(ctrl_act));

    p_fallback_r8: assert property (@(posedge ref_clk) disable iff (por_rst || sys_rst)
        (rst_req || $rose(irq)) |-> !sel_main);

    p_sticky_cause_r9: assert property (@(posedge ref_clk) disable iff (por_rst)
        $fell(sts_fail) |-> $past(reg_we && reg_addr == 2'd1 && reg_wdata[0]));
endmodule

bind osc_freq_monitor osc_freq_monitor_chk u_chk (.*);

// File: tb/tb_osc_freq_monitor.sv
`timescale 1ns/1ps
module tb_osc_freq_monitor;
    localparam int WIN = 64;
    localparam int DLO = 48;
    localparam int DHI = 80;
    localparam int NV  = 7;
    // main half period (ps), bounds, expected fast/slow
    localparam int V_HALF[NV] = '{2000, 1000, 4000, 1500, 3000, 2500, 1000};
    localparam int V_LO[NV]   = '{56, 56, 56, 56, 56, 56, 100};
    localparam int V_HI[NV]   = '{72, 72, 72, 72, 72, 72, 140};
    localparam int V_FAST[NV] = '{0, 1, 0, 1, 0, 0, 0};
    localparam int V_SLOW[NV] = '{0, 0, 1, 0, 1, 1, 0};

    logic        ref_clk = 0, main_clk = 0;
    logic        por_rst = 1, sys_rst = 0;
    logic        reg_we = 0;
    logic [1:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        sel_main, rst_req, irq;

    int main_half_ps = 2000;
    bit main_run = 1;
    int n_tests = 0, n_fail = 0;
    bit mon_on = 0;
    int pulses = 0, run = 0, maxrun = 0;
    logic [31:0] rv;

    osc_freq_monitor #(.WIN_CYCLES(WIN), .DEF_LO(DLO), .DEF_HI(DHI)) dut (
        .ref_clk(ref_clk), .main_clk(main_clk), .por_rst(por_rst), .sys_rst(sys_rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sel_main(sel_main), .rst_req(rst_req), .irq(irq)
    );

    always #2 ref_clk = ~ref_clk;

    initial begin
        forever begin
            if (main_run) begin
                #(main_half_ps * 1ps);
                main_clk = ~main_clk;
            end else begin
                @(posedge ref_clk);
            end
        end
    end

    always @(negedge ref_clk) begin
        if (mon_on) begin
            if (rst_req) begin
                pulses++;
                run++;
                if (run > maxrun) maxrun = run;
            end else begin
                run = 0;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_por();
        @(negedge ref_clk) por_rst = 1;
        repeat (10) @(negedge ref_clk);
        por_rst = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge ref_clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge ref_clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge ref_clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_win(input int n);
        repeat (n * WIN) @(posedge ref_clk);
        @(negedge ref_clk);
    endtask

    initial begin
        #200us;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R10: power-on state
        do_por();
        rd(2'd0, rv); check("R10 ctrl", rv, 32'h0);
        rd(2'd1, rv); check("R10 status", rv, 32'h0);
        rd(2'd2, rv); check("R10 limits", rv, {16'(DHI), 16'(DLO)});
        check("R10 sel_main", {31'b0, sel_main}, 32'h0);
        check("R10 irq", {31'b0, irq}, 32'h0);

        // table walk: R1, R2, R3, R6, R8
        for (int i = 0; i < NV; i++) begin
            main_half_ps = V_HALF[i];
            main_run = 1;
            do_por();
            wr(2'd2, {16'(V_HI[i]), 16'(V_LO[i])});
            wr(2'd0, 32'h7);
            wait_win(6);
            rd(2'd1, rv);
            check((V_FAST[i] != 0) ? "R2 cause" : (V_SLOW[i] != 0) ? "R3 cause" : "R1 cause",
                  rv, {29'b0, V_SLOW[i][0], V_FAST[i][0], V_SLOW[i][0] | V_FAST[i][0]});
            check("R6 irq level", {31'b0, irq}, {31'b0, V_SLOW[i][0] | V_FAST[i][0]});
            check("R8 sel_main", {31'b0, sel_main}, {31'b0, ~(V_SLOW[i][0] | V_FAST[i][0])});
        end

        // R5: checking disabled with a bad clock
        main_half_ps = 1000;
        do_por();
        wr(2'd2, {16'd72, 16'd56});
        wr(2'd0, 32'h6);
        wait_win(6);
        rd(2'd1, rv); check("R5 status", rv, 32'h0);
        check("R5 sel_main", {31'b0, sel_main}, 32'h1);
        check("R5 irq", {31'b0, irq}, 32'h0);

        // R7: reset action, then R9 across system reset
        do_por();
        wr(2'd2, {16'd72, 16'd56});
        pulses = 0; maxrun = 0; run = 0;
        mon_on = 1;
        wr(2'd0, 32'h5);
        wait_win(6);
        mon_on = 0;
        check("R7 pulse seen", {31'b0, pulses > 0}, 32'h1);
        check("R7 pulse width", maxrun, 32'd1);
        check("R7 irq low", {31'b0, irq}, 32'h0);
        check("R8 fallback", {31'b0, sel_main}, 32'h0);
        @(negedge ref_clk) sys_rst = 1;
        repeat (10) @(negedge ref_clk);
        sys_rst = 0;
        rd(2'd1, rv); check("R9 survives sys_rst", {31'b0, rv[0]}, 32'h1);
        rd(2'd0, rv); check("R9 ctrl cleared by sys_rst", rv, 32'h0);
        do_por();
        rd(2'd1, rv); check("R9 por clears", rv, 32'h0);

        // R6 hold, R9 write-0 / write-1, R8 reselect
        main_half_ps = 1000;
        do_por();
        wr(2'd2, {16'd72, 16'd56});
        wr(2'd0, 32'h7);
        wait_win(4);
        check("R6 irq set", {31'b0, irq}, 32'h1);
        main_half_ps = 2000;
        wait_win(4);
        check("R6 irq held", {31'b0, irq}, 32'h1);
        check("R8 held without write", {31'b0, sel_main}, 32'h0);
        wr(2'd1, 32'h0);
        rd(2'd1, rv); check("R9 write 0 no effect", rv, 32'h3);
        wr(2'd1, 32'h1);
        rd(2'd1, rv); check("R9 w1c bit0 only", rv, 32'h2);
        check("R6 irq cleared", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'h7);
        wait_win(4);
        check("R8 reselect main", {31'b0, sel_main}, 32'h1);
        check("R1 good clock quiet", {31'b0, irq}, 32'h0);

        // R4: stopped main clock
        do_por();
        wr(2'd2, {16'd72, 16'd56});
        wr(2'd0, 32'h7);
        wait_win(3);
        rd(2'd1, rv); check("R4 before stop", rv, 32'h0);
        main_run = 0;
        wait_win(4);
        rd(2'd1, rv); check("R4 stall slow", rv, 32'h5);
        check("R4 fallback", {31'b0, sel_main}, 32'h0);
        main_run = 1;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule